// File: doc/BRIEF.md
# Burst Image Loader Sequencer

This block runs on the host side of an I2C link and takes care of loading a firmware image into a target device. It steers a byte-level I2C controller through four commands: start, stop, write byte, and read byte with a chosen ACK or NACK. The controller answers each command with a response that carries the target's ACK and any byte that was read.

Once `go` arrives, the sequencer places the target in burst mode by writing a keyed command to the command register. It then reads the data register back, which tells it the bus address the target has opened for the image. Next it takes image bytes from a ready/valid source and sends them to that address. The bytes travel in write transactions that each have a bounded length, and the target's internal pointer keeps advancing from one transaction to the next. At the end the block reports either done, or an error together with a code that names the phase in which the error occurred.

Top module: `burst_loader_seq`

## Requirements
- R1: The sequence begins with a start, then the address byte 0x42 (device 0x21 with the write bit 0), then the data bytes 0x08 (command register), 0x04 (count), 0x50, 0x42, 0x4D, 0x73, and finally a stop.
- R2: The query comes next. It is a start, then 0x42, then 0x09 (data register), then a repeated start with no stop in between, then 0x43 (device 0x21 with the read bit 1).
- R3: Read bytes are numbered from 0, and byte 0 is the length. The sequencer reads byte 0 up to and including byte 5. It ACKs every byte except byte 5, which it NACKs, and then it issues a stop. The burst address is bits [6:0] of byte 5.
- R4: If the length byte is below 5, the block does no payload transfer. After the stop it reports error code 3.
- R5: A payload transaction is a start, then the address byte {burst address, 0}, then 1 to MAX_BURST image bytes, then a stop. Longer images carry on in further transactions, and no offset is sent.
- R6: The number of image bytes sent is exactly `img_len`, and then `done` rises. If `img_len` is 0, the block raises `done` without any payload transaction.
- R7: A NACK of any address or written byte causes a stop and then `err`. The `err_code` value is 1 for the command write, 2 for the query (this includes its read address) and 4 for the payload.
- R8: An image byte is taken only in a cycle where `src_valid` and `src_ready` are both high. While the block is waiting for a byte, no command is presented.
- R9: Only one command is outstanding at a time. A command that has been presented stays unchanged until it is accepted. Encodings: 0 start, 1 stop, 2 write, 3 read.
- R10: After reset, all outputs are low. `done` or `err` stays high until the next `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start pulse, accepted when not busy |
| img_len | input | LEN_W | Image length in bytes |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Image fully sent |
| err | output | 1 | Sequence aborted |
| err_code | output | 3 | 1 command, 2 query, 3 short length, 4 payload |
| src_valid | input | 1 | Image byte available |
| src_data | input | 8 | Image byte |
| src_ready | output | 1 | Sequencer takes the byte |
| cmd_valid | output | 1 | Command presented to the I2C controller |
| cmd_ready | input | 1 | Controller accepts the command |
| cmd_op | output | 2 | 0 start, 1 stop, 2 write, 3 read |
| cmd_wdata | output | 8 | Byte to write |
| cmd_rd_nack | output | 1 | NACK the byte being read |
| rsp_valid | input | 1 | Command completed |
| rsp_ack | input | 1 | Target ACKed the written byte |
| rsp_rdata | input | 8 | Byte read |

## Verification
The bench sets MAX_BURST to 7 and keeps the other parameters at their defaults. With that limit, the cases where an image splits into several transactions, ends exactly on a transaction boundary, or overruns a boundary by one byte each need only a few dozen bytes. The short limit also makes it cheap to NACK the address of a continuation transaction. The controller model pulses `cmd_ready` to hold commands back, and it can stall the source, so the hold and idle rules are tested under backpressure. The default transaction limit of 4095 is never reached by any length the bench runs.

// File: rtl/burst_loader_pkg.sv
// Shared types for the burst image loader.
// Assumes: the op encoding below matches the byte-level I2C controller.
package burst_loader_pkg;

    localparam int STEP_W  = 4;
    localparam int KEY_LEN = 4;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } i2c_op_e;

    typedef enum logic [1:0] {PH_CMD, PH_QRY, PH_RD, PH_PAY} phase_e;

    typedef enum logic [2:0] {
        ERR_NONE = 3'd0,
        ERR_CMD  = 3'd1,
        ERR_QRY  = 3'd2,
        ERR_LEN  = 3'd3,
        ERR_PAY  = 3'd4
    } err_e;

    typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_PULL, S_DONE, S_ERR} state_e;

    // Key bytes that unlock burst mode, by position.
    function automatic logic [7:0] key_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'h50;
            2'd1:    return 8'h42;
            2'd2:    return 8'h4D;
            default: return 8'h73;
        endcase
    endfunction

    // Error code reported for a NACK seen in a given phase.
    function automatic err_e phase_err(input phase_e p);
        case (p)
            PH_CMD:  return ERR_CMD;
            PH_PAY:  return ERR_PAY;
            default: return ERR_QRY;
        endcase
    endfunction

endpackage

// File: rtl/bl_cmd_decode.sv
// Maps the sequencer position (phase, step) onto the I2C command to present.
// Assumes: ADDR_IDX + 1 fits in STEP_W bits; an abort always forces a stop.
module bl_cmd_decode
    import burst_loader_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h21,
    parameter logic [7:0] CMD_REG  = 8'h08,
    parameter logic [7:0] DATA_REG = 8'h09,
    parameter int         ADDR_IDX = 5
) (
    input  phase_e            phase,
    input  logic [STEP_W-1:0] step,
    input  logic              aborting,
    input  logic [6:0]        baddr,
    input  logic [7:0]        pay_byte,
    output i2c_op_e           op,
    output logic [7:0]        wdata,
    output logic              rd_nack
);
    localparam logic [STEP_W-1:0] LAST_RD = STEP_W'(ADDR_IDX);

    // Command lookup for every phase and step.
    always_comb begin
        op      = OP_STOP;
        wdata   = 8'h00;
        rd_nack = 1'b0;
        if (!aborting) begin
            unique case (phase)
                PH_CMD: begin
                    case (step)
                        4'd0: op = OP_START;
                        4'd1: begin op = OP_WRITE; wdata = {DEV_ADDR, 1'b0}; end
                        4'd2: begin op = OP_WRITE; wdata = CMD_REG; end
                        4'd3: begin op = OP_WRITE; wdata = 8'(KEY_LEN); end
                        4'd4, 4'd5, 4'd6, 4'd7: begin
                            op    = OP_WRITE;
                            wdata = key_byte(2'(step - 4'd4));
                        end
                        default: op = OP_STOP;
                    endcase
                end
                PH_QRY: begin
                    case (step)
                        4'd0: op = OP_START;
                        4'd1: begin op = OP_WRITE; wdata = {DEV_ADDR, 1'b0}; end
                        4'd2: begin op = OP_WRITE; wdata = DATA_REG; end
                        4'd3: op = OP_START;
                        4'd4: begin op = OP_WRITE; wdata = {DEV_ADDR, 1'b1}; end
                        default: op = OP_STOP;
                    endcase
                end
                PH_RD: begin
                    if (step <= LAST_RD) begin
                        op      = OP_READ;
                        rd_nack = (step == LAST_RD);
                    end
                end
                PH_PAY: begin
                    case (step)
                        4'd0: op = OP_START;
                        4'd1: begin op = OP_WRITE; wdata = {baddr, 1'b0}; end
                        4'd2: begin op = OP_WRITE; wdata = pay_byte; end
                        default: op = OP_STOP;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/bl_payload_ctr.sv
// Tracks the image bytes still to send and the bytes in the current transaction.
// Assumes: take never arrives with nothing left or with a full transaction.
module bl_payload_ctr #(
    parameter int LEN_W     = 16,
    parameter int MAX_BURST = 4095
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             take,
    input  logic             chunk_clr,
    output logic             rem_zero,
    output logic             chunk_full
);
    localparam int CH_W = $clog2(MAX_BURST + 1);

    logic [LEN_W-1:0] rem_q;
    logic [CH_W-1:0]  chunk_q;

    // Remaining count: loaded at go, decremented per byte taken.
    always_ff @(posedge clk) begin
        if (!rst_n)    rem_q <= '0;
        else if (load) rem_q <= len;
        else if (take) rem_q <= rem_q - 1'b1;
    end

    // Per-transaction count: cleared at go and after each stop.
    always_ff @(posedge clk) begin
        if (!rst_n)                 chunk_q <= '0;
        else if (load || chunk_clr) chunk_q <= '0;
        else if (take)              chunk_q <= chunk_q + 1'b1;
    end

    assign rem_zero   = (rem_q == '0);
    assign chunk_full = (chunk_q == CH_W'(MAX_BURST));

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !rem_zero);                                  // R6
    AST_CHUNK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !chunk_full);                                // R5
endmodule

// File: rtl/burst_loader_seq.sv
// Host-side sequencer: unlocks burst mode, reads back the burst address, then
// streams the image in transactions of at most MAX_BURST bytes.
// Assumes: the controller responds exactly once to every accepted command.
module burst_loader_seq
    import burst_loader_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h21,
    parameter logic [7:0] CMD_REG   = 8'h08,
    parameter logic [7:0] DATA_REG  = 8'h09,
    parameter int         ADDR_IDX  = 5,
    parameter int         MAX_BURST = 4095,
    parameter int         LEN_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [LEN_W-1:0] img_len,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [2:0]       err_code,
    input  logic             src_valid,
    input  logic [7:0]       src_data,
    output logic             src_ready,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [1:0]       cmd_op,
    output logic [7:0]       cmd_wdata,
    output logic             cmd_rd_nack,
    input  logic             rsp_valid,
    input  logic             rsp_ack,
    input  logic [7:0]       rsp_rdata
);
    localparam logic [STEP_W-1:0] CMD_LAST = STEP_W'(4 + KEY_LEN);
    localparam logic [STEP_W-1:0] QRY_LAST = STEP_W'(4);
    localparam logic [STEP_W-1:0] RD_ADDR  = STEP_W'(ADDR_IDX);
    localparam logic [STEP_W-1:0] RD_STOP  = STEP_W'(ADDR_IDX + 1);

    state_e            state;
    phase_e            phase;
    logic [STEP_W-1:0] step;
    logic              aborting;
    err_e              err_q;
    logic [7:0]        len_q;
    logic [6:0]        baddr_q;
    logic [7:0]        pay_byte;
    i2c_op_e           dec_op;
    logic              rem_zero, chunk_full;
    logic              start, take, chunk_clr;

    assign start     = go && (state == S_IDLE || state == S_DONE || state == S_ERR);
    assign take      = (state == S_PULL) && src_valid;
    assign chunk_clr = (state == S_WAIT) && rsp_valid && !aborting
                       && (phase == PH_PAY) && (step == 4'd3);

    bl_cmd_decode #(
        .DEV_ADDR(DEV_ADDR), .CMD_REG(CMD_REG), .DATA_REG(DATA_REG), .ADDR_IDX(ADDR_IDX)
    ) dec_i (
        .phase(phase), .step(step), .aborting(aborting), .baddr(baddr_q),
        .pay_byte(pay_byte), .op(dec_op), .wdata(cmd_wdata), .rd_nack(cmd_rd_nack)
    );

    bl_payload_ctr #(.LEN_W(LEN_W), .MAX_BURST(MAX_BURST)) ctr_i (
        .clk(clk), .rst_n(rst_n), .load(start), .len(img_len), .take(take),
        .chunk_clr(chunk_clr), .rem_zero(rem_zero), .chunk_full(chunk_full)
    );

    // Main sequencer: issue one command, wait for its response, choose the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            phase    <= PH_CMD;
            step     <= '0;
            aborting <= 1'b0;
            err_q    <= ERR_NONE;
            len_q    <= '0;
            baddr_q  <= '0;
            pay_byte <= '0;
        end else begin
            case (state)
                S_IDLE, S_DONE, S_ERR: begin
                    if (start) begin
                        state    <= S_ISSUE;
                        phase    <= PH_CMD;
                        step     <= '0;
                        aborting <= 1'b0;
                        err_q    <= ERR_NONE;
                    end
                end
                S_ISSUE: if (cmd_ready) state <= S_WAIT;
                S_PULL: begin
                    if (src_valid) begin
                        pay_byte <= src_data;
                        state    <= S_ISSUE;
                    end
                end
                S_WAIT: begin
                    if (rsp_valid) begin
                        if (aborting) begin
                            state <= S_ERR;
                        end else if (dec_op == OP_WRITE && !rsp_ack) begin
                            aborting <= 1'b1;
                            err_q    <= phase_err(phase);
                            state    <= S_ISSUE;
                        end else begin
                            state <= S_ISSUE;
                            unique case (phase)
                                PH_CMD: begin
                                    if (step == CMD_LAST) begin phase <= PH_QRY; step <= '0; end
                                    else step <= step + 4'd1;
                                end
                                PH_QRY: begin
                                    if (step == QRY_LAST) begin phase <= PH_RD; step <= '0; end
                                    else step <= step + 4'd1;
                                end
                                PH_RD: begin
                                    if (step == '0)     len_q   <= rsp_rdata;
                                    if (step == RD_ADDR) baddr_q <= rsp_rdata[6:0];
                                    if (step == RD_STOP) begin
                                        if (len_q < 8'(ADDR_IDX)) begin
                                            err_q <= ERR_LEN;
                                            state <= S_ERR;
                                        end else if (rem_zero) begin
                                            state <= S_DONE;
                                        end else begin
                                            phase <= PH_PAY;
                                            step  <= '0;
                                        end
                                    end else begin
                                        step <= step + 4'd1;
                                    end
                                end
                                PH_PAY: begin
                                    case (step)
                                        4'd0: step <= 4'd1;
                                        4'd1: begin step <= 4'd2; state <= S_PULL; end
                                        4'd2: begin
                                            if (rem_zero || chunk_full) step <= 4'd3;
                                            else state <= S_PULL;
                                        end
                                        default: begin
                                            if (rem_zero) state <= S_DONE;
                                            else step <= '0;
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign cmd_valid = (state == S_ISSUE);
    assign cmd_op    = dec_op;
    assign src_ready = (state == S_PULL);
    assign busy      = (state == S_ISSUE) || (state == S_WAIT) || (state == S_PULL);
    assign done      = (state == S_DONE);
    assign err       = (state == S_ERR);
    assign err_code  = err_q;

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_wdata)); // R9
    AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT) && rsp_valid && !aborting && (dec_op == OP_WRITE) && !rsp_ack
        |=> cmd_valid && (cmd_op == 2'(OP_STOP)));                                          // R7
    AST_ERR_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != 3'd0));                                                        // R7
    AST_SHORT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PAY) |-> (len_q >= 8'(ADDR_IDX)));                                     // R4
    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rem_zero);                                                                 // R6
endmodule

// File: tb/burst_loader_seq_tb_top.sv
module burst_loader_seq_tb_top;
    import burst_loader_pkg::*;

    localparam int MAXB = 7;

    typedef struct packed {
        logic [15:0] len;
        logic [7:0]  lenb;
        logic [6:0]  baddr;
        logic [15:0] nack_at;
        logic        stall;
        logic [2:0]  xerr;
        logic [15:0] xbytes;
        logic [7:0]  xtxn;
    } vec_t;

    // len, length byte, burst addr, write index to NACK, stall, exp err, exp bytes, exp txns
    localparam vec_t VEC [0:14] = '{
        '{16'd5,  8'h40, 7'h30, 16'hFFFF, 1'b0, 3'd0, 16'd5,  8'd1},
        '{16'd14, 8'h40, 7'h30, 16'hFFFF, 1'b1, 3'd0, 16'd14, 8'd2},
        '{16'd15, 8'h40, 7'h30, 16'hFFFF, 1'b0, 3'd0, 16'd15, 8'd3},
        '{16'd1,  8'h40, 7'h30, 16'hFFFF, 1'b1, 3'd0, 16'd1,  8'd1},
        '{16'd0,  8'h40, 7'h30, 16'hFFFF, 1'b0, 3'd0, 16'd0,  8'd0},
        '{16'd20, 8'h40, 7'h55, 16'hFFFF, 1'b1, 3'd0, 16'd20, 8'd3},
        '{16'd6,  8'h04, 7'h30, 16'hFFFF, 1'b0, 3'd3, 16'd0,  8'd0},
        '{16'd3,  8'h05, 7'h30, 16'hFFFF, 1'b0, 3'd0, 16'd3,  8'd1},
        '{16'd4,  8'h40, 7'h30, 16'd0,    1'b0, 3'd1, 16'd0,  8'd0},
        '{16'd4,  8'h40, 7'h30, 16'd5,    1'b0, 3'd1, 16'd0,  8'd0},
        '{16'd4,  8'h40, 7'h30, 16'd8,    1'b0, 3'd2, 16'd0,  8'd0},
        '{16'd4,  8'h40, 7'h30, 16'd10,   1'b0, 3'd4, 16'd0,  8'd0},
        '{16'd9,  8'h40, 7'h30, 16'd13,   1'b1, 3'd4, 16'd2,  8'd1},
        '{16'd10, 8'h40, 7'h30, 16'd18,   1'b0, 3'd4, 16'd7,  8'd1},
        '{16'd4,  8'h40, 7'h30, 16'd9,    1'b0, 3'd2, 16'd0,  8'd0}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [15:0] cur_len = '0;
    logic [7:0]  cur_lenb = 8'h40;
    logic [6:0]  cur_baddr = 7'h30;
    logic [15:0] cur_nack = 16'hFFFF;
    logic        cur_stall = 1'b0;

    logic busy, done, err, src_valid, src_ready, cmd_valid, cmd_rd_nack;
    logic [2:0]  err_code;
    logic [7:0]  src_data, cmd_wdata;
    logic [1:0]  cmd_op;
    logic        m_rdy, rsp_valid, rsp_ack;
    logic [7:0]  rsp_rdata;

    burst_loader_seq #(.MAX_BURST(MAXB)) dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .img_len(cur_len), .busy(busy), .done(done),
        .err(err), .err_code(err_code), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .cmd_valid(cmd_valid), .cmd_ready(m_rdy), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .cmd_rd_nack(cmd_rd_nack), .rsp_valid(rsp_valid),
        .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [7:0] pat(input int k);
        return 8'(k * 7 + 3);
    endfunction

    // Image source with optional stall pattern.
    logic [15:0] src_k;
    logic [31:0] cyc;
    assign src_valid = rst_n && (src_k < cur_len) && (!cur_stall || cyc[1]);
    assign src_data  = pat(int'(src_k));
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) src_k <= '0;
        else if (src_valid && src_ready) src_k <= src_k + 1'b1;
    end
    initial cyc = '0;

    // Controller and target model.
    logic        m_pend, in_txn, exp_addr, cur_pay, rs_seen, prev_hold;
    logic [1:0]  m_dly, prev_op;
    logic [7:0]  prev_wd, log_b [0:7];
    int          rd_idx, wr_idx, pay_cnt, pay_bad, txns, txn_bytes, max_tb;
    int          logn, last_rd_idx, nack_rds, viol;

    always @(posedge clk) begin : model
        logic ack_v;
        int   v;
        if (!rst_n) begin
            m_rdy <= 1'b0; m_pend <= 1'b0; m_dly <= '0; rsp_valid <= 1'b0;
            rsp_ack <= 1'b0; rsp_rdata <= '0; in_txn <= 1'b0; exp_addr <= 1'b0;
            cur_pay <= 1'b0; rs_seen <= 1'b0; prev_hold <= 1'b0; prev_op <= '0;
            prev_wd <= '0; rd_idx <= 0; wr_idx <= 0; pay_cnt <= 0; pay_bad <= 0;
            txns <= 0; txn_bytes <= 0; max_tb <= 0; logn <= 0; last_rd_idx <= -1;
            nack_rds <= 0; viol <= 0;
        end else begin
            v = 0;
            rsp_valid <= 1'b0;
            if (cmd_valid && (m_pend || rsp_valid)) v++;
            if (prev_hold && (!cmd_valid || cmd_op != prev_op || cmd_wdata != prev_wd)) v++;
            if (cmd_valid && src_ready) v++;
            viol <= viol + v;
            prev_hold <= cmd_valid && !m_rdy;
            prev_op   <= cmd_op;
            prev_wd   <= cmd_wdata;
            if (m_pend) begin
                m_rdy <= 1'b0;
                if (m_dly == 2'd0) begin m_pend <= 1'b0; rsp_valid <= 1'b1; end
                else m_dly <= m_dly - 1'b1;
            end else if (cmd_valid && m_rdy) begin
                m_pend <= 1'b1; m_dly <= 2'd1; m_rdy <= 1'b0;
                rsp_ack <= 1'b1;
                case (cmd_op)
                    2'd0: begin
                        if (in_txn) rs_seen <= 1'b1;
                        in_txn <= 1'b1; exp_addr <= 1'b1; cur_pay <= 1'b0;
                    end
                    2'd1: begin in_txn <= 1'b0; cur_pay <= 1'b0; end
                    2'd2: begin
                        ack_v = (wr_idx[15:0] != cur_nack);
                        wr_idx <= wr_idx + 1;
                        if (exp_addr) begin
                            exp_addr <= 1'b0;
                            if (cmd_wdata[7:1] == 7'h21) rd_idx <= 0;
                            else if (cmd_wdata == {cur_baddr, 1'b0}) begin
                                if (ack_v) begin cur_pay <= 1'b1; txns <= txns + 1; txn_bytes <= 0; end
                            end else ack_v = 1'b0;
                        end else if (cur_pay) begin
                            if (ack_v) begin
                                if (cmd_wdata != pat(pay_cnt)) pay_bad <= pay_bad + 1;
                                pay_cnt <= pay_cnt + 1;
                                txn_bytes <= txn_bytes + 1;
                                if (txn_bytes + 1 > max_tb) max_tb <= txn_bytes + 1;
                            end
                        end else begin
                            if (logn < 8) log_b[logn] <= cmd_wdata;
                            logn <= logn + 1;
                        end
                        rsp_ack <= ack_v;
                    end
                    default: begin
                        if (rd_idx == 0)      rsp_rdata <= cur_lenb;
                        else if (rd_idx == 5) rsp_rdata <= {1'b0, cur_baddr};
                        else if (rd_idx < 5)  rsp_rdata <= 8'(8'h10 + rd_idx);
                        else                  rsp_rdata <= 8'hEE;
                        rd_idx <= rd_idx + 1;
                        if (cmd_rd_nack) begin last_rd_idx <= rd_idx; nack_rds <= nack_rds + 1; end
                    end
                endcase
            end else begin
                m_rdy <= ~m_rdy;
            end
        end
    end

    int n_chk = 0, n_pass = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (ok) n_pass++;
        else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    endtask

    task automatic wait_end(output bit ok);
        int n = 0;
        while (!(done || err) && n < 20000) begin @(negedge clk); n++; end
        ok = (n < 20000);
    endtask

    task automatic run_vec(input vec_t v);
        bit fin;
        int xmax;
        cur_len = v.len; cur_lenb = v.lenb; cur_baddr = v.baddr;
        cur_nack = v.nack_at; cur_stall = v.stall;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        wait_end(fin);
        chk(fin, "R10 watchdog", 0, 1);
        if (v.xerr == 3'd0)
            chk(done && !err, "R6 done", int'({done, err}), 2);
        else
            chk(err && err_code == v.xerr, v.xerr == 3'd3 ? "R4 code" : "R7 code",
                int'(err_code), int'(v.xerr));
        chk(pay_cnt == int'(v.xbytes), "R6 bytes", pay_cnt, int'(v.xbytes));
        chk(pay_bad == 0, "R8 data order", pay_bad, 0);
        chk(txns == int'(v.xtxn), "R5 transactions", txns, int'(v.xtxn));
        chk(!in_txn, "R7 bus released", int'(in_txn), 0);
        chk(viol == 0, "R9 handshake", viol, 0);
        if (v.xerr == 3'd0 && v.len != 0) begin
            xmax = (int'(v.len) < MAXB) ? int'(v.len) : MAXB;
            chk(max_tb == xmax, "R5 chunk size", max_tb, xmax);
        end
        if (v.xerr == 3'd0 || v.xerr == 3'd3 || v.xerr == 3'd4) begin
            chk(logn == 7 && log_b[0] == 8'h08 && log_b[1] == 8'h04 && log_b[2] == 8'h50
                && log_b[3] == 8'h42 && log_b[4] == 8'h4D && log_b[5] == 8'h73,
                "R1 command bytes", logn, 7);
            chk(log_b[6] == 8'h09 && rs_seen, "R2 query", int'(log_b[6]), 9);
            chk(last_rd_idx == 5 && nack_rds == 1, "R3 read end", last_rd_idx, 5);
        end
        if (v.xerr == 3'd1 || v.xerr == 3'd2 || v.xerr == 3'd3)
            chk(src_k == 0, "R4 no pull on early error", int'(src_k), 0);
        repeat (5) @(negedge clk);
        chk((done || err) && !busy, "R10 status held", int'({done, err}), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !cmd_valid && !src_ready, "R10 reset state",
            int'({busy, done, err, cmd_valid, src_ready}), 0);
        foreach (VEC[i]) run_vec(VEC[i]);

        // Reset in the middle of a payload.
        cur_len = 16'd20; cur_lenb = 8'h40; cur_baddr = 7'h30; cur_nack = 16'hFFFF; cur_stall = 1'b0;
        rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
        go = 1'b1; @(negedge clk); go = 1'b0;
        repeat (150) @(negedge clk);
        rst_n = 1'b0; @(negedge clk);
        chk(!busy && !done && !err && !cmd_valid && !src_ready, "R10 reset mid-run",
            int'({busy, done, err, cmd_valid, src_ready}), 0);
        rst_n = 1'b1; repeat (4) @(negedge clk);
        chk(!busy && !cmd_valid, "R10 idle after reset", int'({busy, cmd_valid}), 0);

        $display("%0d/%0d checks passed", n_pass, n_chk);
        $finish;
    end
endmodule